// File: doc/BRIEF.md
# ADC Bring-up and Single-Shot Conversion Sequencer

This block is the control state machine that sits above a serial command engine for a multi-channel delta-sigma ADC. After reset it drives the converter through a fixed configuration sequence. The sequence issues a reset command and waits a number of ADC master-clock periods. It then leaves continuous read-out mode and patches the rate, reference and per-channel settings registers with read-modify-write pairs. Channels that are not enabled are powered down. Finally it runs one offset calibration cycle with a long settling wait, so that later conversions do not time out.

Once the configuration is in place, the block serves single-shot conversion requests. Each request issues a start command and then watches the active-low data-ready line for a falling edge, bounded by a timeout. On the edge it issues a data read followed by a stop and reports success. If the timeout expires first, it issues the stop without reading and reports an error. Every command travels to the command engine over a request/done handshake. All waits are derived from a parameterised system clock frequency.

Top module: `adc_bringup_seq`

## Requirements
- R1: After reset the command stream is, in order: opcode 0x06, opcode 0x11, read then write of register 0x01, read then write of register 0x03, read then write of register 0x05+i for each channel i in ascending order, opcode 0x1A, opcode 0x08, opcode 0x0A. `init_done` rises after the last of these and stays high. Command kinds are encoded 0 = opcode byte, 1 = register read, 2 = register write, 3 = sample-data read. For register commands, `cmd_byte` carries the register address.
- R2: Between completion of the reset opcode and the request for opcode 0x11, no request is raised for exactly ceil(RESET_ADC_CLKS*CLK_HZ/ADC_CLK_HZ) cycles.
- R3: The write to register 0x01 places `cfg_rate` in bits [2:0] and keeps bits [7:3] as read.
- R4: With the internal reference (`cfg_ref_ext`=0), the write to register 0x03 sets bit 7, sets bit 5 to `cfg_ref_4v` and keeps the other bits. With an external reference it clears bit 7 and keeps bits [6:0].
- R5: For an enabled channel, the write places the gain field in bits [6:4] and the mux field in bits [2:0], keeping bits 7 and 3. The gain field maps gains 1,2,4,8,12 to codes 1,2,4,5,6, and any other gain to code 1. The mux field is the input when it is 0, 1, 3 or 4, and 0 otherwise.
- R6: For a channel whose `cfg_ch_en` bit is 0, the write sets bit 7 and keeps bits [6:0].
- R7: Between completion of the calibration start (0x08) and the request for the stop (0x0A), no request is raised for exactly ceil(CAL_WAIT_US*CLK_HZ/1e6) cycles.
- R8: A `conv_req` pulse while idle after bring-up produces opcode 0x08, then a data read (kind 3) once a falling edge is seen on `drdy_n`, then opcode 0x0A, followed by a one-cycle `conv_done` pulse with `conv_err` low.
- R9: If no falling edge arrives within ceil(TIMEOUT_US*CLK_HZ/1e6) cycles of the start completing, the block issues opcode 0x0A with no data read, and then gives a one-cycle `conv_err` pulse with `conv_done` low.
- R10: `conv_req` is ignored while bring-up or a conversion is in progress: no extra start opcode is issued.
- R11: A `drdy_n` level that is already low when the conversion starts does not count as data-ready; only a high-to-low transition during the wait does.
- R12: While `cmd_req` is high and `cmd_done` is low, `cmd_req`, `cmd_kind`, `cmd_byte` and `cmd_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_req | input | 1 | Single-shot conversion request pulse |
| drdy_n | input | 1 | Active-low data-ready from the converter (asynchronous) |
| cfg_rate | input | 3 | Data-rate code for register 0x01 bits [2:0] |
| cfg_ref_ext | input | 1 | 1 = external reference, 0 = internal reference |
| cfg_ref_4v | input | 1 | Internal reference level, 1 = 4 V, 0 = 2.4 V |
| cfg_ch_en | input | NCH | Channel enable mask, bit i for channel i |
| cfg_gain | input | 4*NCH | Per-channel numeric gain, channel i at [4i+3:4i] |
| cfg_mux | input | 3*NCH | Per-channel mux selection, channel i at [3i+2:3i] |
| cmd_req | output | 1 | Command request to the command engine |
| cmd_kind | output | 2 | 0 opcode, 1 register read, 2 register write, 3 data read |
| cmd_byte | output | 8 | Opcode or register address |
| cmd_wdata | output | 8 | Register write value |
| cmd_done | input | 1 | One-cycle completion from the command engine |
| cmd_rdata | input | 8 | Register read value, valid with `cmd_done` |
| init_done | output | 1 | Bring-up complete |
| conv_done | output | 1 | One-cycle pulse: conversion finished with data |
| conv_err | output | 1 | One-cycle pulse: conversion timed out |

## Verification
Every cycle, the assertions check several properties. The request fields must stay frozen until the engine answers. The shared wait counter must step down by one and its expiry must not repeat. A data read may only follow a seen falling edge, and a timeout must lead straight to the stop. A start may only be entered from idle, the two outcome pulses must never coincide, and `init_done` must never fall. The exact command order, the patched register values for each reference and channel mode, and the cycle length of the reset, calibration and timeout waits can only be shown by the bench. It does this by modelling the engine and register file across several configurations. The same applies to ignored requests and to a data-ready line held low across a start.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {
    CK_OPCODE = 2'd0,
    CK_RDREG  = 2'd1,
    CK_WRREG  = 2'd2,
    CK_RDDATA = 2'd3
  } cmd_kind_e;

  localparam logic [7:0] OP_RESET     = 8'h06;
  localparam logic [7:0] OP_START     = 8'h08;
  localparam logic [7:0] OP_STOP      = 8'h0A;
  localparam logic [7:0] OP_OFFCAL    = 8'h1A;
  localparam logic [7:0] OP_HALT_CONT = 8'h11;

  localparam logic [7:0] ADDR_RATE    = 8'h01;
  localparam logic [7:0] ADDR_REF     = 8'h03;
  localparam logic [7:0] ADDR_CH_BASE = 8'h05;

  typedef enum logic [4:0] {
    ST_RST_CMD, ST_RST_WAIT, ST_HALT, ST_RATE_RD, ST_RATE_WR,
    ST_REF_RD, ST_REF_WR, ST_CH_RD, ST_CH_WR, ST_OCAL,
    ST_CAL_GO, ST_CAL_WAIT, ST_CAL_HALT, ST_IDLE,
    ST_CV_GO, ST_CV_WAIT, ST_CV_READ, ST_CV_HALT
  } seq_state_e;

  typedef enum logic [1:0] {
    PT_NONE = 2'd0,
    PT_RATE = 2'd1,
    PT_REF  = 2'd2,
    PT_CHAN = 2'd3
  } patch_sel_e;

  function automatic logic [2:0] gain_code(input logic [3:0] g);
    logic [2:0] c;
    case (g)
      4'd2:    c = 3'd2;
      4'd4:    c = 3'd4;
      4'd8:    c = 3'd5;
      4'd12:   c = 3'd6;
      default: c = 3'd1;
    endcase
    return c;
  endfunction

  function automatic logic [2:0] mux_code(input logic [2:0] m);
    logic [2:0] c;
    case (m)
      3'd0, 3'd1, 3'd3, 3'd4: c = m;
      default:                c = 3'd0;
    endcase
    return c;
  endfunction

  function automatic logic [7:0] patch_rate(input logic [7:0] old, input logic [2:0] code);
    return {old[7:3], code};
  endfunction

  function automatic logic [7:0] patch_ref(input logic [7:0] old, input logic ext,
                                           input logic v4);
    logic [7:0] r;
    if (ext) r = {1'b0, old[6:0]};
    else     r = {1'b1, old[6], v4, old[4:0]};
    return r;
  endfunction

  function automatic logic [7:0] patch_chan(input logic [7:0] old, input logic en,
                                            input logic [3:0] g, input logic [2:0] m);
    logic [7:0] r;
    if (en) r = {old[7], gain_code(g), old[3], mux_code(m)};
    else    r = {1'b1, old[6:0]};
    return r;
  endfunction

  function automatic longint unsigned ceil_cycles(input longint unsigned num,
                                                  input longint unsigned den);
    longint unsigned q;
    q = (num + den - 64'd1) / den;
    if (q == 64'd0) q = 64'd1;
    return q;
  endfunction

  function automatic longint unsigned max3(input longint unsigned a, input longint unsigned b,
                                           input longint unsigned c);
    longint unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          run,
  output logic          expire,
  output logic [TW-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (run && cnt != '0)   cnt <= cnt - TW'(1);
  end

  assign expire = run && (cnt == TW'(1));

  // R2 / R7 / R9: the shared wait counter steps down by exactly one per running cycle
  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt > TW'(1)) |=> (cnt == $past(cnt) - TW'(1)));

  // R7: an expiry is a single event unless the counter is reloaded
  a_r7_expire_once: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !expire);

endmodule

// File: rtl/adcseq_fall_det.sv
module adcseq_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drdy_n,
  input  logic arm,
  output logic fall
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_sync
      if (k == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= drdy_n;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[k] <= 1'b1;
          else        sync_q[k] <= sync_q[k-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign fall = arm && prev_q && !sync_q[STAGES-1];

endmodule

// File: rtl/adcseq_patch.sv
module adcseq_patch
  import adcseq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CHW = 3
) (
  input  patch_sel_e       sel,
  input  logic [CHW-1:0]   ch,
  input  logic [7:0]       old,
  input  logic [2:0]       cfg_rate,
  input  logic             cfg_ref_ext,
  input  logic             cfg_ref_4v,
  input  logic [NCH-1:0]   cfg_ch_en,
  input  logic [4*NCH-1:0] cfg_gain,
  input  logic [3*NCH-1:0] cfg_mux,
  output logic [7:0]       wdata
);

  logic       ch_en_sel;
  logic [3:0] ch_gain_sel;
  logic [2:0] ch_mux_sel;

  always_comb begin
    ch_en_sel   = cfg_ch_en[ch];
    ch_gain_sel = cfg_gain[4*ch +: 4];
    ch_mux_sel  = cfg_mux[3*ch +: 3];
  end

  always_comb begin
    case (sel)
      PT_RATE: wdata = patch_rate(old, cfg_rate);
      PT_REF:  wdata = patch_ref(old, cfg_ref_ext, cfg_ref_4v);
      PT_CHAN: wdata = patch_chan(old, ch_en_sel, ch_gain_sel, ch_mux_sel);
      default: wdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/adc_bringup_seq.sv
module adc_bringup_seq
  import adcseq_pkg::*;
#(
  parameter int unsigned NCH            = 8,
  parameter int unsigned CLK_HZ         = 200_000_000,
  parameter int unsigned ADC_CLK_HZ     = 2_048_000,
  parameter int unsigned RESET_ADC_CLKS = 18,
  parameter int unsigned CAL_WAIT_US    = 153_000,
  parameter int unsigned TIMEOUT_US     = 6_000,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_req,
  input  logic             drdy_n,
  input  logic [2:0]       cfg_rate,
  input  logic             cfg_ref_ext,
  input  logic             cfg_ref_4v,
  input  logic [NCH-1:0]   cfg_ch_en,
  input  logic [4*NCH-1:0] cfg_gain,
  input  logic [3*NCH-1:0] cfg_mux,
  output logic             cmd_req,
  output logic [1:0]       cmd_kind,
  output logic [7:0]       cmd_byte,
  output logic [7:0]       cmd_wdata,
  input  logic             cmd_done,
  input  logic [7:0]       cmd_rdata,
  output logic             init_done,
  output logic             conv_done,
  output logic             conv_err
);

  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam longint unsigned RST_CYC =
    ceil_cycles(64'(RESET_ADC_CLKS) * 64'(CLK_HZ), 64'(ADC_CLK_HZ));
  localparam longint unsigned CAL_CYC =
    ceil_cycles(64'(CAL_WAIT_US) * 64'(CLK_HZ), 64'd1_000_000);
  localparam longint unsigned TO_CYC =
    ceil_cycles(64'(TIMEOUT_US) * 64'(CLK_HZ), 64'd1_000_000);
  localparam longint unsigned MAX_CYC = max3(RST_CYC, CAL_CYC, TO_CYC);
  localparam int TW = $clog2(MAX_CYC + 64'd1);
  localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

  seq_state_e     state, state_nx;
  logic [CHW-1:0] ch_q;
  logic [7:0]     rd_q;
  logic           err_q;

  // named internal events
  logic           tmr_load, tmr_run, tmr_expire;
  logic [TW-1:0]  tmr_val, tmr_cnt;
  logic           drdy_fall, wait_armed, tmo_evt, read_evt;
  patch_sel_e     patch_sel;
  logic [7:0]     patch_val;

  adcseq_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .expire   (tmr_expire),
    .cnt      (tmr_cnt)
  );

  adcseq_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .drdy_n (drdy_n),
    .arm    (wait_armed),
    .fall   (drdy_fall)
  );

  adcseq_patch #(.NCH(NCH), .CHW(CHW)) u_patch (
    .sel         (patch_sel),
    .ch          (ch_q),
    .old         (rd_q),
    .cfg_rate    (cfg_rate),
    .cfg_ref_ext (cfg_ref_ext),
    .cfg_ref_4v  (cfg_ref_4v),
    .cfg_ch_en   (cfg_ch_en),
    .cfg_gain    (cfg_gain),
    .cfg_mux     (cfg_mux),
    .wdata       (patch_val)
  );

  // timer control: one counter serves all three waits
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (cmd_done) begin
      case (state)
        ST_RST_CMD: begin tmr_load = 1'b1; tmr_val = TW'(RST_CYC); end
        ST_CAL_GO:  begin tmr_load = 1'b1; tmr_val = TW'(CAL_CYC); end
        ST_CV_GO:   begin tmr_load = 1'b1; tmr_val = TW'(TO_CYC);  end
        default:    ;
      endcase
    end
  end

  assign tmr_run    = (state == ST_RST_WAIT) || (state == ST_CAL_WAIT) || (state == ST_CV_WAIT);
  assign wait_armed = (state == ST_CV_WAIT);
  assign tmo_evt    = wait_armed && tmr_expire && !drdy_fall;
  assign read_evt   = wait_armed && drdy_fall;

  // command outputs, decoded from the state alone
  always_comb begin
    cmd_req   = 1'b1;
    cmd_kind  = CK_OPCODE;
    cmd_byte  = 8'h00;
    patch_sel = PT_NONE;
    case (state)
      ST_RST_CMD:  cmd_byte = OP_RESET;
      ST_HALT:     cmd_byte = OP_HALT_CONT;
      ST_RATE_RD:  begin cmd_kind = CK_RDREG; cmd_byte = ADDR_RATE; end
      ST_RATE_WR:  begin cmd_kind = CK_WRREG; cmd_byte = ADDR_RATE; patch_sel = PT_RATE; end
      ST_REF_RD:   begin cmd_kind = CK_RDREG; cmd_byte = ADDR_REF; end
      ST_REF_WR:   begin cmd_kind = CK_WRREG; cmd_byte = ADDR_REF; patch_sel = PT_REF; end
      ST_CH_RD:    begin cmd_kind = CK_RDREG; cmd_byte = ADDR_CH_BASE + 8'(ch_q); end
      ST_CH_WR:    begin
                     cmd_kind  = CK_WRREG;
                     cmd_byte  = ADDR_CH_BASE + 8'(ch_q);
                     patch_sel = PT_CHAN;
                   end
      ST_OCAL:     cmd_byte = OP_OFFCAL;
      ST_CAL_GO:   cmd_byte = OP_START;
      ST_CAL_HALT: cmd_byte = OP_STOP;
      ST_CV_GO:    cmd_byte = OP_START;
      ST_CV_READ:  cmd_kind = CK_RDDATA;
      ST_CV_HALT:  cmd_byte = OP_STOP;
      default:     cmd_req = 1'b0;
    endcase
  end

  assign cmd_wdata = patch_val;

  // next-state logic
  always_comb begin
    state_nx = state;
    case (state)
      ST_RST_CMD:  if (cmd_done)   state_nx = ST_RST_WAIT;
      ST_RST_WAIT: if (tmr_expire) state_nx = ST_HALT;
      ST_HALT:     if (cmd_done)   state_nx = ST_RATE_RD;
      ST_RATE_RD:  if (cmd_done)   state_nx = ST_RATE_WR;
      ST_RATE_WR:  if (cmd_done)   state_nx = ST_REF_RD;
      ST_REF_RD:   if (cmd_done)   state_nx = ST_REF_WR;
      ST_REF_WR:   if (cmd_done)   state_nx = ST_CH_RD;
      ST_CH_RD:    if (cmd_done)   state_nx = ST_CH_WR;
      ST_CH_WR:    if (cmd_done)   state_nx = (ch_q == LAST_CH) ? ST_OCAL : ST_CH_RD;
      ST_OCAL:     if (cmd_done)   state_nx = ST_CAL_GO;
      ST_CAL_GO:   if (cmd_done)   state_nx = ST_CAL_WAIT;
      ST_CAL_WAIT: if (tmr_expire) state_nx = ST_CAL_HALT;
      ST_CAL_HALT: if (cmd_done)   state_nx = ST_IDLE;
      ST_IDLE:     if (conv_req)   state_nx = ST_CV_GO;
      ST_CV_GO:    if (cmd_done)   state_nx = ST_CV_WAIT;
      ST_CV_WAIT:  begin
                     if (read_evt)     state_nx = ST_CV_READ;
                     else if (tmo_evt) state_nx = ST_CV_HALT;
                   end
      ST_CV_READ:  if (cmd_done)   state_nx = ST_CV_HALT;
      ST_CV_HALT:  if (cmd_done)   state_nx = ST_IDLE;
      default:     state_nx = ST_RST_CMD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RST_CMD;
      ch_q      <= '0;
      rd_q      <= 8'h00;
      err_q     <= 1'b0;
      init_done <= 1'b0;
      conv_done <= 1'b0;
      conv_err  <= 1'b0;
    end else begin
      state     <= state_nx;
      conv_done <= 1'b0;
      conv_err  <= 1'b0;
      if (cmd_done && (state == ST_RATE_RD || state == ST_REF_RD || state == ST_CH_RD))
        rd_q <= cmd_rdata;
      if (state == ST_CH_WR && cmd_done && ch_q != LAST_CH)
        ch_q <= ch_q + CHW'(1);
      if (state == ST_CAL_HALT && cmd_done)
        init_done <= 1'b1;
      if (state == ST_CV_GO)
        err_q <= 1'b0;
      else if (tmo_evt)
        err_q <= 1'b1;
      if (state == ST_CV_HALT && cmd_done) begin
        conv_done <= !err_q;
        conv_err  <= err_q;
      end
    end
  end

  // R12: request fields hold until the engine answers
  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_done) |=> (cmd_req && $stable(cmd_kind) && $stable(cmd_byte)
                                && $stable(cmd_wdata)));

  // R8 / R9: the two outcome pulses never coincide
  a_r8_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_done && conv_err));

  // R1: bring-up completion is sticky
  a_r1_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R10: a conversion start is only entered from idle
  a_r10_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CV_GO && $past(state) != ST_CV_GO) |-> ($past(state) == ST_IDLE));

  // R8: a data read is only entered after a seen falling edge
  a_r8_read_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CV_READ && $past(state) == ST_CV_WAIT) |-> $past(drdy_fall));

  // R9: an expired wait goes straight to the stop command
  a_r9_timeout_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (state == ST_CV_HALT));

endmodule

// File: tb/adc_bringup_seq_bench.sv
module adc_bringup_seq_bench;

  localparam int NCH    = 4;
  localparam int CLKHZ  = 1_000_000;
  localparam int ADCHZ  = 250_000;
  localparam int RSTCLK = 18;
  localparam int CALUS  = 150;
  localparam int TOUS   = 40;

  localparam int EXP_RST = (RSTCLK * CLKHZ + ADCHZ - 1) / ADCHZ;
  localparam int EXP_CAL = (CALUS * (CLKHZ / 1_000_000));
  localparam int EXP_TO  = (TOUS * (CLKHZ / 1_000_000));

  logic             clk = 1'b0;
  logic             rst_n;
  logic             conv_req;
  logic             drdy_n;
  logic [2:0]       cfg_rate;
  logic             cfg_ref_ext;
  logic             cfg_ref_4v;
  logic [NCH-1:0]   cfg_ch_en;
  logic [4*NCH-1:0] cfg_gain;
  logic [3*NCH-1:0] cfg_mux;
  logic             cmd_req;
  logic [1:0]       cmd_kind;
  logic [7:0]       cmd_byte;
  logic [7:0]       cmd_wdata;
  logic             cmd_done;
  logic [7:0]       cmd_rdata;
  logic             init_done;
  logic             conv_done;
  logic             conv_err;

  adc_bringup_seq #(
    .NCH(NCH), .CLK_HZ(CLKHZ), .ADC_CLK_HZ(ADCHZ), .RESET_ADC_CLKS(RSTCLK),
    .CAL_WAIT_US(CALUS), .TIMEOUT_US(TOUS), .SYNC_STAGES(2)
  ) u_adc_bringup_seq (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .drdy_n(drdy_n),
    .cfg_rate(cfg_rate), .cfg_ref_ext(cfg_ref_ext), .cfg_ref_4v(cfg_ref_4v),
    .cfg_ch_en(cfg_ch_en), .cfg_gain(cfg_gain), .cfg_mux(cfg_mux),
    .cmd_req(cmd_req), .cmd_kind(cmd_kind), .cmd_byte(cmd_byte), .cmd_wdata(cmd_wdata),
    .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
    .init_done(init_done), .conv_done(conv_done), .conv_err(conv_err)
  );

  always #2.5 clk = ~clk;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [7:0] regs [0:31];
  logic [7:0] regs0 [0:31];
  logic [1:0] log_k [0:63];
  logic [7:0] log_b [0:63];
  logic [7:0] log_w [0:63];
  int         log_seen [0:63];
  int         log_done [0:63];
  int         log_n = 0;
  int         done_cnt = 0;
  int         err_cnt = 0;

  logic [1:0] e_k;
  logic [7:0] e_b, e_w;
  int         e_seen, e_dly;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      report();
    end
  end

  always @(negedge clk) begin
    if (conv_done) done_cnt++;
    if (conv_err)  err_cnt++;
  end

  // command engine and register file model
  initial begin
    cmd_done  = 1'b0;
    cmd_rdata = 8'h00;
    forever begin
      @(negedge clk);
      cmd_done = 1'b0;
      if (rst_n && cmd_req) begin
        e_k = cmd_kind; e_b = cmd_byte; e_w = cmd_wdata; e_seen = cyc;
        e_dly = $urandom_range(0, 3);
        repeat (e_dly) @(negedge clk);
        if (e_k == 2'd1) cmd_rdata = regs[e_b[4:0]];
        if (e_k == 2'd2) regs[e_b[4:0]] = e_w;
        if (log_n < 64) begin
          log_k[log_n] = e_k; log_b[log_n] = e_b; log_w[log_n] = e_w;
          log_seen[log_n] = e_seen; log_done[log_n] = cyc;
          log_n++;
        end
        cmd_done = 1'b1;
      end
    end
  end

  // bench-side expectations, written from the requirements
  function automatic int b_gain(input int g);
    if (g == 8)  return 5;
    if (g == 12) return 6;
    if (g == 1 || g == 2 || g == 4) return g;
    return 1;
  endfunction

  function automatic int b_mux(input int m);
    if (m == 0 || m == 1 || m == 3 || m == 4) return m;
    return 0;
  endfunction

  function automatic logic [7:0] b_chan(input logic [7:0] old, input bit en, input int g,
                                        input int m);
    if (!en) return old | 8'h80;
    return (old & 8'h88) | 8'(b_gain(g) << 4) | 8'(b_mux(m));
  endfunction

  function automatic logic [7:0] b_ref(input logic [7:0] old, input bit ext, input bit v4);
    if (ext) return old & 8'h7F;
    return (old & 8'h5F) | 8'h80 | (v4 ? 8'h20 : 8'h00);
  endfunction

  function automatic int gap(input int i);
    return log_seen[i+1] - log_done[i] - 1;
  endfunction

  task automatic set_config(input int run);
    int gl [0:7];
    gl[0] = 0; gl[1] = 1; gl[2] = 2; gl[3] = 3; gl[4] = 4; gl[5] = 8; gl[6] = 12; gl[7] = 15;
    cfg_rate = 3'($urandom_range(0, 7));
    for (int c = 0; c < NCH; c++) begin
      cfg_gain[4*c +: 4] = 4'(gl[$urandom_range(0, 7)]);
      cfg_mux[3*c +: 3]  = 3'($urandom_range(0, 7));
    end
    case (run)
      0: begin
           cfg_ch_en = '1; cfg_ref_ext = 1'b0; cfg_ref_4v = 1'b1;
           cfg_gain = {4'd12, 4'd8, 4'd2, 4'd1};
           cfg_mux  = {3'd4, 3'd3, 3'd1, 3'd0};
         end
      1: begin cfg_ch_en = 4'b0101; cfg_ref_ext = 1'b1; cfg_ref_4v = 1'b1; end
      2: begin cfg_ch_en = '0; cfg_ref_ext = 1'b0; cfg_ref_4v = 1'b0; end
      default: begin
           cfg_ch_en   = NCH'($urandom);
           cfg_ref_ext = 1'($urandom);
           cfg_ref_4v  = 1'($urandom);
         end
    endcase
  endtask

  task automatic run_init(input int run);
    int n, lim, base;
    logic [7:0] ev;
    rst_n = 1'b0;
    conv_req = 1'b0;
    drdy_n = 1'b1;
    set_config(run);
    repeat (3) @(negedge clk);
    for (int a = 0; a < 32; a++) begin
      regs[a]  = 8'($urandom);
      regs0[a] = regs[a];
    end
    log_n = 0;
    // reset state (R1)
    check(init_done == 1'b0 && conv_done == 1'b0 && conv_err == 1'b0, "R1 reset outputs",
          {init_done, conv_done, conv_err}, 0);
    check(cmd_byte == 8'h06 && cmd_kind == 2'd0, "R1 first command in reset", cmd_byte, 8'h06);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    conv_req = 1'b1;            // R10: request during bring-up is ignored
    @(negedge clk);
    conv_req = 1'b0;
    lim = 0;
    while (!init_done && lim < 3000) begin @(negedge clk); lim++; end
    repeat (5) @(negedge clk);
    n = 9 + 2 * NCH;
    check(init_done == 1'b1, "R1 init_done raised", init_done, 1);
    check(log_n == n, "R1 R10 bring-up command count", log_n, n);
    if (log_n == n) begin
      check(log_k[0] == 0 && log_b[0] == 8'h06, "R1 reset opcode", log_b[0], 8'h06);
      check(log_k[1] == 0 && log_b[1] == 8'h11, "R1 continuous-off opcode", log_b[1], 8'h11);
      check(gap(0) == EXP_RST, "R2 reset wait cycles", gap(0), EXP_RST);
      check(log_k[2] == 1 && log_b[2] == 8'h01 && log_k[3] == 2 && log_b[3] == 8'h01,
            "R1 rate read-modify-write", log_b[3], 8'h01);
      ev = {regs0[1][7:3], cfg_rate};
      check(log_w[3] == ev, "R3 rate register value", log_w[3], ev);
      check(log_k[4] == 1 && log_b[4] == 8'h03 && log_k[5] == 2 && log_b[5] == 8'h03,
            "R1 reference read-modify-write", log_b[5], 8'h03);
      ev = b_ref(regs0[3], cfg_ref_ext, cfg_ref_4v);
      check(log_w[5] == ev, "R4 reference register value", log_w[5], ev);
      for (int c = 0; c < NCH; c++) begin
        base = 6 + 2 * c;
        check(log_k[base] == 1 && log_b[base] == 8'(5 + c) && log_k[base+1] == 2 &&
              log_b[base+1] == 8'(5 + c), "R1 channel register order", log_b[base+1], 5 + c);
        ev = b_chan(regs0[5+c], cfg_ch_en[c], int'(cfg_gain[4*c +: 4]), int'(cfg_mux[3*c +: 3]));
        if (cfg_ch_en[c])
          check(log_w[base+1] == ev, "R5 enabled channel value", log_w[base+1], ev);
        else
          check(log_w[base+1] == ev, "R6 disabled channel value", log_w[base+1], ev);
      end
      base = 6 + 2 * NCH;
      check(log_b[base] == 8'h1A && log_b[base+1] == 8'h08 && log_b[base+2] == 8'h0A,
            "R1 calibration opcodes", {log_b[base], log_b[base+1], log_b[base+2]}, 24'h1A080A);
      check(gap(base + 1) == EXP_CAL, "R7 calibration wait cycles", gap(base + 1), EXP_CAL);
    end
  endtask

  // mode 0: data-ready edge, mode 1: no edge, mode 2: line held low across start
  task automatic do_conv(input int mode);
    int st, d0, r0, lim;
    st = log_n; d0 = done_cnt; r0 = err_cnt;
    if (mode == 2) begin drdy_n = 1'b0; repeat (5) @(negedge clk); end
    conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    lim = 0;
    while (log_n <= st && lim < 100) begin @(negedge clk); lim++; end
    if (mode == 0) begin
      repeat ($urandom_range(2, 6)) @(negedge clk);
      conv_req = 1'b1;          // R10: request during conversion is ignored
      @(negedge clk);
      conv_req = 1'b0;
      drdy_n = 1'b0;
      repeat (3) @(negedge clk);
      drdy_n = 1'b1;
    end
    lim = 0;
    while (done_cnt == d0 && err_cnt == r0 && lim < 500) begin @(negedge clk); lim++; end
    repeat (20) @(negedge clk);
    drdy_n = 1'b1;
    repeat (4) @(negedge clk);
    if (mode == 0) begin
      check(done_cnt - d0 == 1 && err_cnt == r0, "R8 conv_done pulse", done_cnt - d0, 1);
      check(log_n - st == 3, "R8 R10 conversion command count", log_n - st, 3);
      if (log_n - st == 3)
        check(log_b[st] == 8'h08 && log_k[st+1] == 2'd3 && log_b[st+2] == 8'h0A,
              "R8 start/read/stop order", log_k[st+1], 3);
    end else begin
      check(err_cnt - r0 == 1 && done_cnt == d0,
            (mode == 1) ? "R9 conv_err pulse" : "R11 held-low level gives timeout",
            err_cnt - r0, 1);
      check(log_n - st == 2, "R9 start/stop without read", log_n - st, 2);
      if (log_n - st == 2) begin
        check(log_b[st] == 8'h08 && log_b[st+1] == 8'h0A && log_k[st+1] == 2'd0,
              "R9 stop follows start", log_b[st+1], 8'h0A);
        check(gap(st) == EXP_TO, "R9 timeout wait cycles", gap(st), EXP_TO);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    conv_req = 1'b0;
    drdy_n = 1'b1;
    cfg_rate = '0; cfg_ref_ext = 1'b0; cfg_ref_4v = 1'b0;
    cfg_ch_en = '0; cfg_gain = '0; cfg_mux = '0;
    repeat (4) @(negedge clk);
    for (int run = 0; run < 6; run++) begin
      run_init(run);
      do_conv(0);
      do_conv(1);
      do_conv(2);
      do_conv(0);
    end
    report();
  end

endmodule